// File: doc/BRIEF.md
# Multichannel DMA Channel Status and Interrupt Register File

This block holds the software-visible control and status state of a multichannel DMA controller. Each channel owns one 32-bit word that combines writable control fields (run enable, descriptor-less mode, interrupt enables, end-of-receive handling), sticky event flags and live read-only state. Two shared registers sit beside the per-channel words. One is a summary register with one pending bit per channel. The other holds a per-channel byte-alignment enable. Software reaches all of it through a plain 32-bit read/write port, and reads return data combinationally from the addressed register.

The channel engines drive single-cycle event pulses into the block: start, end, bus error and end-of-receive. They also drive a busy level and a request-pending level for each channel. The block turns these into sticky flags, tracks when each channel has stopped, and raises one combined interrupt line. Software clears the flags by writing back the word it has just read. The run, descriptor-mode, end-of-receive and alignment settings are driven back out to the engines.

Top module: `dma_status_regs`

## Requirements
- R1: After reset, every channel word reads 0x00000008 (only the stopped bit, bit 3, set), the alignment and summary registers read 0, all control outputs are 0 and `irq_o` is 0.
- R2: Channel n's word is at byte address 4*n for n < NUM_CH. The alignment register is at 0xA0 and the summary register is at 0xF0. Any other address, including an unaligned one, reads 0 and ignores writes. The summary register ignores writes.
- R3: Bits 31 (run), 30 (no-descriptor mode), 29 (stop interrupt enable), 28 (end-of-receive interrupt enable), 27 (jump on end-of-receive) and 26 (stop on end-of-receive) are read/write. Bits 31, 30, 27 and 26 drive `run_o`, `nodesc_o`, `eor_jmp_o` and `eor_stop_o` for that channel.
- R4: A pulse on `ev_end_i`, `ev_start_i`, `ev_berr_i` or `ev_eor_i` sets bit 2, 1, 0 or 9 of the channel word, respectively, on the next edge. Each such flag stays set until a write carries a 1 in its position. A 0 in that position leaves the flag as it is. An event in the same cycle as its clear leaves the flag set.
- R5: Bit 8 shows `req_pend_i` of the channel live. Bits 8 and 3 ignore writes. Bits 25, 24, 23 to 11 and 7 to 4 always read 0.
- R6: Bit 3 (stopped) becomes 1 on the edge after a cycle in which run is 0 and `busy_i` is 0. It becomes 0 on the edge after a cycle in which run is 1.
- R7: Bit 10 (compare status) is set by writing 1 to bit 25 and cleared by writing 1 to bit 24. When both are 1, the set wins. When neither is 1, the bit holds.
- R8: Summary bit i is 1 while channel i has any of bits 2, 1 or 0 set, or bit 9 with bit 28, or bit 3 with bit 29. `irq_o` is the OR of all summary bits.
- R9: Alignment register bits [NUM_CH-1:0] are read/write and drive `align_o`. The bits above them read 0.
- R10: An end-of-receive pulse on a channel whose bit 26 is set clears that channel's run bit on the same edge, overriding a write in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when 1 with req_i |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of addr_i, combinational |
| ev_start_i | input | NUM_CH | Start event pulse per channel |
| ev_end_i | input | NUM_CH | End event pulse per channel |
| ev_berr_i | input | NUM_CH | Bus error event pulse per channel |
| ev_eor_i | input | NUM_CH | End-of-receive event pulse per channel |
| busy_i | input | NUM_CH | Transfer in flight per channel |
| req_pend_i | input | NUM_CH | Peripheral request pending per channel |
| run_o | output | NUM_CH | Run enable per channel |
| nodesc_o | output | NUM_CH | No-descriptor mode per channel |
| eor_jmp_o | output | NUM_CH | Jump to next descriptor on end-of-receive |
| eor_stop_o | output | NUM_CH | Stop on end-of-receive |
| align_o | output | NUM_CH | Byte-alignment enable per channel |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions check the following on every cycle and for every channel:
- an event pulse always sets its flag on the next edge;
- a set flag survives any cycle that does not write a 1 in its position;
- the stopped bit follows run and busy one edge later;
- an end-of-receive pulse with stop-on-end-of-receive set always drops run;
- a set bus-error flag always shows on `irq_o`;
- at most one channel word is write-selected per cycle.

Only the bench scenarios show the following:
- the exact address map and the zeros read from unmapped addresses;
- that writes to the read-only bits and to the summary register are ignored;
- the clear-by-write-back sequence;
- the priority of the compare-status set over its clear;
- the summary gating of end-of-receive and stop flags by their enables.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int REG_AW = 8;
  localparam logic [REG_AW-1:0] ALIGN_OFS = 8'hA0;
  localparam logic [REG_AW-1:0] SUMM_OFS  = 8'hF0;

  // control/status word bit positions (decoded by software and engines)
  localparam int B_RUN     = 31;
  localparam int B_NODESC  = 30;
  localparam int B_STOPIE  = 29;
  localparam int B_EORIE   = 28;
  localparam int B_EORJMP  = 27;
  localparam int B_EORSTOP = 26;
  localparam int B_CMPSET  = 25;
  localparam int B_CMPCLR  = 24;
  localparam int B_CMP     = 10;
  localparam int B_EORF    = 9;
  localparam int B_REQP    = 8;
  localparam int B_STOPPED = 3;
  localparam int B_ENDF    = 2;
  localparam int B_STARTF  = 1;
  localparam int B_BERRF   = 0;

  typedef struct packed {
    logic run;
    logic nodesc;
    logic stop_ie;
    logic eor_ie;
    logic eor_jmp;
    logic eor_stop;
  } ctl_t;

  typedef struct packed {
    logic cmp;
    logic eor;
    logic endf;
    logic startf;
    logic berr;
  } flg_t;

  typedef enum logic [1:0] {SEL_NONE, SEL_CHAN, SEL_ALIGN, SEL_SUMM} sel_e;
endpackage

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
  import dma_regs_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  input  logic        ev_start_i,
  input  logic        ev_end_i,
  input  logic        ev_berr_i,
  input  logic        ev_eor_i,
  input  logic        busy_i,
  input  logic        req_pend_i,
  output logic [31:0] csr_o,
  output logic        pend_o,
  output logic        run_o,
  output logic        nodesc_o,
  output logic        eor_jmp_o,
  output logic        eor_stop_o
);
  ctl_t ctl_q, ctl_d;
  flg_t flg_q, flg_d;
  logic stopped_q;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_i) begin
      ctl_d.run      = wdata_i[B_RUN];
      ctl_d.nodesc   = wdata_i[B_NODESC];
      ctl_d.stop_ie  = wdata_i[B_STOPIE];
      ctl_d.eor_ie   = wdata_i[B_EORIE];
      ctl_d.eor_jmp  = wdata_i[B_EORJMP];
      ctl_d.eor_stop = wdata_i[B_EORSTOP];
    end
    // end-of-receive stop beats a concurrent software write
    if (ev_eor_i && ctl_q.eor_stop) ctl_d.run = 1'b0;
  end

  always_comb begin
    flg_d.endf   = (flg_q.endf   & ~(wr_i & wdata_i[B_ENDF]))   | ev_end_i;
    flg_d.startf = (flg_q.startf & ~(wr_i & wdata_i[B_STARTF])) | ev_start_i;
    flg_d.berr   = (flg_q.berr   & ~(wr_i & wdata_i[B_BERRF]))  | ev_berr_i;
    flg_d.eor    = (flg_q.eor    & ~(wr_i & wdata_i[B_EORF]))   | ev_eor_i;
    flg_d.cmp    = flg_q.cmp;
    if (wr_i && wdata_i[B_CMPSET])      flg_d.cmp = 1'b1;
    else if (wr_i && wdata_i[B_CMPCLR]) flg_d.cmp = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q     <= '0;
      flg_q     <= '0;
      stopped_q <= 1'b1;
    end else begin
      ctl_q     <= ctl_d;
      flg_q     <= flg_d;
      stopped_q <= ~ctl_q.run & ~busy_i;
    end
  end

  always_comb begin
    csr_o            = '0;
    csr_o[B_RUN]     = ctl_q.run;
    csr_o[B_NODESC]  = ctl_q.nodesc;
    csr_o[B_STOPIE]  = ctl_q.stop_ie;
    csr_o[B_EORIE]   = ctl_q.eor_ie;
    csr_o[B_EORJMP]  = ctl_q.eor_jmp;
    csr_o[B_EORSTOP] = ctl_q.eor_stop;
    csr_o[B_CMP]     = flg_q.cmp;
    csr_o[B_EORF]    = flg_q.eor;
    csr_o[B_REQP]    = req_pend_i;
    csr_o[B_STOPPED] = stopped_q;
    csr_o[B_ENDF]    = flg_q.endf;
    csr_o[B_STARTF]  = flg_q.startf;
    csr_o[B_BERRF]   = flg_q.berr;
  end

  assign pend_o = flg_q.endf | flg_q.startf | flg_q.berr
                | (flg_q.eor & ctl_q.eor_ie) | (stopped_q & ctl_q.stop_ie);

  assign run_o      = ctl_q.run;
  assign nodesc_o   = ctl_q.nodesc;
  assign eor_jmp_o  = ctl_q.eor_jmp;
  assign eor_stop_o = ctl_q.eor_stop;

  logic unused_wd;
  assign unused_wd = ^{wdata_i[23:10], wdata_i[8:3]};
endmodule

// File: rtl/dma_align_reg.sv
module dma_align_reg #(
  parameter int NUM_CH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [NUM_CH-1:0] wdata_i,
  output logic [NUM_CH-1:0] align_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   align_o <= '0;
    else if (wr_i) align_o <= wdata_i;
  end
endmodule

// File: rtl/dma_reg_decode.sv
module dma_reg_decode
  import dma_regs_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                         req_i,
  input  logic                         we_i,
  input  logic [REG_AW-1:0]            addr_i,
  input  logic [NUM_CH-1:0][31:0]      csr_i,
  input  logic [NUM_CH-1:0]            align_i,
  input  logic [NUM_CH-1:0]            summ_i,
  output logic [NUM_CH-1:0]            ch_wr_o,
  output logic                         align_wr_o,
  output logic [31:0]                  rdata_o
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [REG_AW:0] CH_LIM = (REG_AW+1)'(4 * NUM_CH);

  sel_e            sel;
  logic [CH_W-1:0] ch_idx;
  logic            wr;

  assign ch_idx = addr_i[CH_W+1:2];
  assign wr     = req_i & we_i;

  always_comb begin
    sel = SEL_NONE;
    if (addr_i[1:0] == 2'b00 && {1'b0, addr_i} < CH_LIM) sel = SEL_CHAN;
    else if (addr_i == ALIGN_OFS)                       sel = SEL_ALIGN;
    else if (addr_i == SUMM_OFS)                        sel = SEL_SUMM;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_wsel
    assign ch_wr_o[g] = wr && sel == SEL_CHAN && ch_idx == CH_W'(g);
  end

  assign align_wr_o = wr && sel == SEL_ALIGN;

  always_comb begin
    rdata_o = '0;
    case (sel)
      SEL_CHAN:  rdata_o = csr_i[ch_idx];
      SEL_ALIGN: rdata_o[NUM_CH-1:0] = align_i;
      SEL_SUMM:  rdata_o[NUM_CH-1:0] = summ_i;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dma_status_regs.sv
module dma_status_regs
  import dma_regs_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [7:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [NUM_CH-1:0] ev_start_i,
  input  logic [NUM_CH-1:0] ev_end_i,
  input  logic [NUM_CH-1:0] ev_berr_i,
  input  logic [NUM_CH-1:0] ev_eor_i,
  input  logic [NUM_CH-1:0] busy_i,
  input  logic [NUM_CH-1:0] req_pend_i,
  output logic [NUM_CH-1:0] run_o,
  output logic [NUM_CH-1:0] nodesc_o,
  output logic [NUM_CH-1:0] eor_jmp_o,
  output logic [NUM_CH-1:0] eor_stop_o,
  output logic [NUM_CH-1:0] align_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0][31:0] csr_w;
  logic [NUM_CH-1:0]       ch_wr;
  logic [NUM_CH-1:0]       pend;
  logic                    align_wr;

  dma_reg_decode #(.NUM_CH(NUM_CH)) u_dec (
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .csr_i      (csr_w),
    .align_i    (align_o),
    .summ_i     (pend),
    .ch_wr_o    (ch_wr),
    .align_wr_o (align_wr),
    .rdata_o    (rdata_o)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dma_chan_csr u_csr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (ch_wr[g]),
      .wdata_i    (wdata_i),
      .ev_start_i (ev_start_i[g]),
      .ev_end_i   (ev_end_i[g]),
      .ev_berr_i  (ev_berr_i[g]),
      .ev_eor_i   (ev_eor_i[g]),
      .busy_i     (busy_i[g]),
      .req_pend_i (req_pend_i[g]),
      .csr_o      (csr_w[g]),
      .pend_o     (pend[g]),
      .run_o      (run_o[g]),
      .nodesc_o   (nodesc_o[g]),
      .eor_jmp_o  (eor_jmp_o[g]),
      .eor_stop_o (eor_stop_o[g])
    );
  end

  dma_align_reg #(.NUM_CH(NUM_CH)) u_align (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (align_wr),
    .wdata_i (wdata_i[NUM_CH-1:0]),
    .align_o (align_o)
  );

  assign irq_o = |pend;
endmodule

// File: rtl/dma_status_regs_chk.sv
module dma_status_regs_chk #(
  parameter int NUM_CH = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [31:0]             wdata_i,
  input logic [NUM_CH-1:0]       ev_end_i,
  input logic [NUM_CH-1:0]       ev_eor_i,
  input logic [NUM_CH-1:0]       busy_i,
  input logic [NUM_CH-1:0]       ch_wr,
  input logic [NUM_CH-1:0][31:0] csr_w,
  input logic                    irq_o
);
  a_r2_one_word_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ch_wr));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    a_r4_end_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_end_i[g] |=> csr_w[g][2]);
    a_r4_berr_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (csr_w[g][0] && !(ch_wr[g] && wdata_i[0])) |=> csr_w[g][0]);
    a_r6_stop_enter: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!csr_w[g][31] && !busy_i[g]) |=> csr_w[g][3]);
    a_r6_run_leaves: assert property (@(posedge clk_i) disable iff (!rst_ni)
      csr_w[g][31] |=> !csr_w[g][3]);
    a_r8_berr_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
      csr_w[g][0] |-> irq_o);
    a_r10_eor_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev_eor_i[g] && csr_w[g][26]) |=> !csr_w[g][31]);
  end
endmodule

bind dma_status_regs dma_status_regs_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wdata_i  (wdata_i),
  .ev_end_i (ev_end_i),
  .ev_eor_i (ev_eor_i),
  .busy_i   (busy_i),
  .ch_wr    (ch_wr),
  .csr_w    (csr_w),
  .irq_o    (irq_o)
);

// File: tb/dma_status_regs_test.sv
`timescale 1ns/1ps
module dma_status_regs_test;
  localparam int NCH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NCH-1:0] ev_start = '0, ev_end = '0, ev_berr = '0, ev_eor = '0;
  logic [NCH-1:0] busy = '0, req_pend = '0;
  logic [NCH-1:0] run, nodesc, eor_jmp, eor_stop, align;
  logic irq;
  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  dma_status_regs #(.NUM_CH(NCH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ev_start_i(ev_start), .ev_end_i(ev_end),
    .ev_berr_i(ev_berr), .ev_eor_i(ev_eor), .busy_i(busy), .req_pend_i(req_pend),
    .run_o(run), .nodesc_o(nodesc), .eor_jmp_o(eor_jmp), .eor_stop_o(eor_stop),
    .align_o(align), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic chk_rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // kind: 0 start, 1 end, 2 bus error, 3 end-of-receive
  task automatic pulse(input int kind, input int ch);
    @(negedge clk);
    case (kind)
      0: ev_start[ch] = 1'b1;
      1: ev_end[ch]   = 1'b1;
      2: ev_berr[ch]  = 1'b1;
      default: ev_eor[ch] = 1'b1;
    endcase
    @(negedge clk);
    ev_start = '0; ev_end = '0; ev_berr = '0; ev_eor = '0;
  endtask

  task automatic t_reset;
    chk_rd("R1 ch0 word", 8'h00, 32'h8);
    chk_rd("R1 ch7 word", 8'h1C, 32'h8);
    chk_rd("R1 align", 8'hA0, 32'h0);
    chk_rd("R1 summary", 8'hF0, 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 run", 32'(run), 32'h0);
  endtask

  task automatic t_ctl;
    wr(8'h04, 32'hFC00_0000);
    chk_rd("R3 ch1 rw bits, R6 stopped lingers", 8'h04, 32'hFC00_0008);
    idle(1);
    chk_rd("R6 stopped cleared after run", 8'h04, 32'hFC00_0000);
    check("R3 run_o", 32'(run), 32'h2);
    check("R3 nodesc_o", 32'(nodesc), 32'h2);
    check("R3 eor_jmp_o", 32'(eor_jmp), 32'h2);
    check("R3 eor_stop_o", 32'(eor_stop), 32'h2);
    chk_rd("R8 summary running", 8'hF0, 32'h0);
  endtask

  task automatic t_stop;
    @(negedge clk); busy[1] = 1'b1;
    wr(8'h04, 32'h0);
    idle(2);
    chk_rd("R6 busy holds off stop", 8'h04, 32'h0);
    busy[1] = 1'b0;
    chk_rd("R6 not yet stopped", 8'h04, 32'h0);
    idle(1);
    chk_rd("R6 stopped after busy drops", 8'h04, 32'h8);
  endtask

  task automatic t_flags;
    logic [31:0] v;
    pulse(1, 2);
    chk_rd("R4 end flag", 8'h08, 32'hC);
    chk_rd("R8 summary end", 8'hF0, 32'h4);
    check("R8 irq end", 32'(irq), 32'h1);
    wr(8'h08, 32'h0);
    chk_rd("R4 zero write keeps flag", 8'h08, 32'hC);
    pulse(0, 2);
    pulse(2, 2);
    rd(8'h08, v);
    check("R4 three flags", v, 32'hF);
    wr(8'h08, v);
    chk_rd("R4 write-back clears", 8'h08, 32'h8);
    chk_rd("R8 summary cleared", 8'hF0, 32'h0);
    check("R8 irq cleared", 32'(irq), 32'h0);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 8'h08; wdata = 32'h4; ev_end[2] = 1'b1;
    @(negedge clk);
    req = 1'b0; we = 1'b0; wdata = '0; ev_end = '0;
    chk_rd("R4 event beats clear", 8'h08, 32'hC);
    wr(8'h08, 32'h4);
    chk_rd("R4 final clear", 8'h08, 32'h8);
  endtask

  task automatic t_eor;
    wr(8'h0C, 32'h9400_0000);
    idle(1);
    check("R3 ch3 run", 32'(run), 32'h8);
    pulse(3, 3);
    chk_rd("R10 eor stops run", 8'h0C, 32'h1400_0200);
    check("R10 run_o dropped", 32'(run), 32'h0);
    chk_rd("R8 summary eor enabled", 8'hF0, 32'h8);
    idle(1);
    chk_rd("R6 stopped after eor stop", 8'h0C, 32'h1400_0208);
    wr(8'h0C, 32'h200);
    chk_rd("R4 eor flag cleared", 8'h0C, 32'h8);
    pulse(3, 4);
    chk_rd("R4 eor flag ch4", 8'h10, 32'h208);
    chk_rd("R8 eor without enable", 8'hF0, 32'h0);
    check("R8 irq eor without enable", 32'(irq), 32'h0);
    wr(8'h10, 32'h200);
  endtask

  task automatic t_stopirq;
    wr(8'h14, 32'h2000_0000);
    chk_rd("R3 stop ie", 8'h14, 32'h2000_0008);
    chk_rd("R8 summary stop", 8'hF0, 32'h20);
    check("R8 irq stop", 32'(irq), 32'h1);
    wr(8'h14, 32'h0);
    chk_rd("R8 summary stop off", 8'hF0, 32'h0);
  endtask

  task automatic t_cmp;
    wr(8'h18, 32'h0200_0000);
    chk_rd("R7 cmp set", 8'h18, 32'h408);
    wr(8'h18, 32'h0);
    chk_rd("R7 cmp holds", 8'h18, 32'h408);
    wr(8'h18, 32'h0100_0000);
    chk_rd("R7 cmp clear", 8'h18, 32'h8);
    wr(8'h18, 32'h0300_0000);
    chk_rd("R7 set wins", 8'h18, 32'h408);
    wr(8'h18, 32'h0100_0000);
  endtask

  task automatic t_ro;
    @(negedge clk); req_pend[7] = 1'b1;
    chk_rd("R5 req pending", 8'h1C, 32'h108);
    wr(8'h1C, 32'h0000_05F8);
    chk_rd("R5 ro bits ignore write", 8'h1C, 32'h108);
    req_pend[7] = 1'b0;
    chk_rd("R5 req pending drops", 8'h1C, 32'h8);
    wr(8'h1C, 32'h00FF_FC00);
    chk_rd("R5 reserved bits zero", 8'h1C, 32'h8);
  endtask

  task automatic t_align;
    wr(8'hA0, 32'hFFFF_FFFF);
    chk_rd("R9 align upper zero", 8'hA0, 32'hFF);
    check("R9 align_o", 32'(align), 32'hFF);
    wr(8'hA0, 32'h5A);
    chk_rd("R9 align pattern", 8'hA0, 32'h5A);
    wr(8'hA0, 32'h5B);
    chk_rd("R9 align rmw", 8'hA0, 32'h5B);
    check("R9 align_o rmw", 32'(align), 32'h5B);
    wr(8'hA0, 32'h0);
  endtask

  task automatic t_map;
    wr(8'h20, 32'hFFFF_FFFF);
    chk_rd("R2 beyond channels reads 0", 8'h20, 32'h0);
    chk_rd("R2 ch0 untouched", 8'h00, 32'h8);
    check("R2 run untouched", 32'(run), 32'h0);
    wr(8'hF0, 32'hFFFF_FFFF);
    chk_rd("R2 summary ignores write", 8'hF0, 32'h0);
    check("R2 irq after summary write", 32'(irq), 32'h0);
    wr(8'h05, 32'h8000_0000);
    chk_rd("R2 unaligned reads 0", 8'h05, 32'h0);
    chk_rd("R2 unaligned write ignored", 8'h04, 32'h8);
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctl();
    t_stop();
    t_flags();
    t_eor();
    t_stopirq();
    t_cmp();
    t_ro();
    t_align();
    t_map();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule